// File: doc/BRIEF.md
# Serial Flash Status Register Controller

This block is the slave-side logic of a serial flash device that serves the status-register instructions only. It watches chip select, serial clock and serial data in, oversamples them with its own system clock, and decodes byte-wide instructions. Three instructions are handled: one that arms writes by setting the write-enable latch, one that streams the status byte back, and one that loads a new status byte. Array reads, programming, erasing and the meaning of the protected ranges are handled elsewhere.

The status byte holds a write-disable bit, two block-protect bits, the write-enable latch and a busy flag. A status write is accepted only when it is framed exactly, when writes are armed, and when the write-disable bit and the active-low protect pin do not together lock the register. An accepted write starts a timed cycle of a programmable number of system clocks. The busy flag stays set for the whole cycle, the register can still be read, and the new protection fields take effect when the cycle ends.

The SPI pins carry no stream payload that could stall, so there is no valid/ready handshake and no back-pressure. The serial master paces every transfer, and the block keeps up with any serial clock whose half period is at least four system clocks.

Top module: `spi_status_ctrl`

## Requirements
- R1: A status write (opcode 8'h01) is refused while the write-enable latch (bit 1) is 0. In that case the status byte stays unchanged and no busy cycle begins.
- R2: A write-enable instruction (opcode 8'h06) sets bit 1 only when chip select rises after exactly 8 bits. With any other bit count it has no effect.
- R3: A status write takes effect only when chip select rises after exactly 16 bits: the opcode followed by one data byte. With 15 or 17 bits the frame is discarded.
- R4: An accepted status write starts a busy cycle of CYCLE_CLKS system clocks. During that cycle bit 0 reads 1, and the status byte stays readable.
- R5: The write-enable latch clears when the busy cycle starts. The new protection fields appear only when the cycle ends, and bit 0 then returns to 0.
- R6: Only bits 7, 3 and 2 take values from the data byte. Bits 6 to 4 always read 0.
- R7: When bit 7 is 1 and the protect pin is low, status writes are refused and the write-enable latch stays set. When bit 7 is 0, status writes proceed at either pin level.
- R8: After a read-status opcode (8'h05), the status byte is shifted out MSB first in SPI mode 0: input is sampled on the rising edge and output changes on the falling edge. The byte repeats for as long as chip select stays low. The output enable is high only after that opcode and only while chip select is low.
- R9: While bit 0 is 1, every instruction other than read-status is ignored.
- R10: After reset the status byte is 8'h00 and the output enable is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used for oversampling and the busy timer |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_cs_n | input | 1 | Chip select, active low |
| spi_sck | input | 1 | Serial clock |
| spi_mosi | input | 1 | Serial data in |
| wprot_n | input | 1 | Write-protect pin, active low |
| spi_miso | output | 1 | Serial data out |
| spi_miso_oe | output | 1 | Output enable for serial data out |

## Verification
Each pin passes through SYNC_STAGES flops, and one more register turns an edge into a state change. A decoded frame end or serial edge therefore shows up in the status three system clocks after the pin moves. A new data-out bit appears three clocks after the falling serial-clock edge. The bench holds each serial-clock phase for four system clocks and samples data out just before it raises the clock, so every bit it reads has already settled. Commit checks wait a full CYCLE_CLKS plus margin after the frame ends. The busy-phase read finishes its snapshot about 80 clocks into the 300-clock cycle, and the exact busy length is checked by a run-length counter in the checker.

// File: rtl/spi_sr_pkg.sv
package spi_sr_pkg;
  localparam logic [7:0] OP_ARM   = 8'h06;
  localparam logic [7:0] OP_READ  = 8'h05;
  localparam logic [7:0] OP_WRITE = 8'h01;
  // writable bits: b7 write-disable, b3/b2 block protect
  localparam logic [7:0] WR_MASK  = 8'b1000_1100;
  localparam int FRAME_ARM_BITS   = 8;
  localparam int FRAME_WRITE_BITS = 16;
endpackage

// File: rtl/sr_pin_sync.sv
module sr_pin_sync #(
  parameter int STAGES = 2,
  parameter int WIDTH  = 4,
  parameter logic [WIDTH-1:0] INIT = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= INIT;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/sr_serdes.sv
module sr_serdes #(
  parameter int BITS_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n_s,
  input  logic              sck_s,
  input  logic              mosi_s,
  input  logic [7:0]        status,
  output logic              frame_end,
  output logic [BITS_W-1:0] frame_bits,
  output logic [7:0]        opcode,
  output logic [7:0]        last_byte,
  output logic              miso,
  output logic              miso_oe
);
  import spi_sr_pkg::*;
  localparam logic [BITS_W-1:0] BITS_MAX = '1;

  logic       sck_q, cs_q, rise, fall, reading;
  logic [2:0] tx_cnt;
  logic [7:0] snap;
  logic [7:0] shifted;

  assign rise      = sck_s & ~sck_q & ~cs_n_s;
  assign fall      = ~sck_s & sck_q & ~cs_n_s;
  assign frame_end = cs_n_s & ~cs_q;
  assign shifted   = {last_byte[6:0], mosi_s};
  assign miso_oe   = reading & ~cs_n_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q      <= 1'b0;
      cs_q       <= 1'b1;
      frame_bits <= '0;
      opcode     <= '0;
      last_byte  <= '0;
      reading    <= 1'b0;
      tx_cnt     <= '0;
      snap       <= '0;
      miso       <= 1'b0;
    end else begin
      sck_q <= sck_s;
      cs_q  <= cs_n_s;
      if (cs_n_s) begin
        frame_bits <= '0;
        reading    <= 1'b0;
        tx_cnt     <= '0;
      end else begin
        if (rise) begin
          last_byte <= shifted;
          if (frame_bits != BITS_MAX) frame_bits <= frame_bits + 1'b1;
          if (frame_bits == BITS_W'(7)) begin
            opcode <= shifted;
            if (shifted == OP_READ) reading <= 1'b1;
          end
        end
        if (fall && reading) begin
          if (tx_cnt == 3'd0) begin
            snap <= status;
            miso <= status[7];
          end else begin
            miso <= snap[~tx_cnt];
          end
          tx_cnt <= tx_cnt + 3'd1;
        end
      end
    end
  end
endmodule

// File: rtl/sr_wcycle.sv
module sr_wcycle #(
  parameter int CYCLE_CLKS = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy,
  output logic done
);
  localparam int CW = $clog2(CYCLE_CLKS + 1);
  logic [CW-1:0] cnt;

  assign done = busy && (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (start && !busy) begin
      busy <= 1'b1;
      cnt  <= CW'(CYCLE_CLKS - 1);
    end else if (busy) begin
      if (cnt == '0) busy <= 1'b0;
      else           cnt  <= cnt - 1'b1;
    end
  end
endmodule

// File: rtl/spi_status_ctrl.sv
module spi_status_ctrl #(
  parameter int SYNC_STAGES = 2,
  parameter int CYCLE_CLKS  = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic spi_cs_n,
  input  logic spi_sck,
  input  logic spi_mosi,
  input  logic wprot_n,
  output logic spi_miso,
  output logic spi_miso_oe
);
  import spi_sr_pkg::*;
  localparam int BITS_W = 5;

  logic cs_s, sck_s, mosi_s, wp_s;
  logic frame_end, busy, done, wel_q, locked, arm_ok, write_ok;
  logic [BITS_W-1:0] frame_bits;
  logic [7:0] opcode, last_byte, pend_q, sr_q, status;

  sr_pin_sync #(.STAGES(SYNC_STAGES), .WIDTH(4), .INIT(4'b1001)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d({wprot_n, spi_mosi, spi_sck, spi_cs_n}),
    .q({wp_s, mosi_s, sck_s, cs_s})
  );

  sr_serdes #(.BITS_W(BITS_W)) u_serdes (
    .clk(clk), .rst_n(rst_n), .cs_n_s(cs_s), .sck_s(sck_s), .mosi_s(mosi_s),
    .status(status), .frame_end(frame_end), .frame_bits(frame_bits),
    .opcode(opcode), .last_byte(last_byte), .miso(spi_miso), .miso_oe(spi_miso_oe)
  );

  sr_wcycle #(.CYCLE_CLKS(CYCLE_CLKS)) u_timer (
    .clk(clk), .rst_n(rst_n), .start(write_ok), .busy(busy), .done(done)
  );

  assign locked   = sr_q[7] & ~wp_s;
  assign arm_ok   = frame_end && !busy && opcode == OP_ARM &&
                    frame_bits == BITS_W'(FRAME_ARM_BITS);
  assign write_ok = frame_end && !busy && opcode == OP_WRITE &&
                    frame_bits == BITS_W'(FRAME_WRITE_BITS) && wel_q && !locked;
  assign status   = (sr_q & WR_MASK) | {6'b0, wel_q, busy};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wel_q  <= 1'b0;
      pend_q <= '0;
      sr_q   <= '0;
    end else begin
      if (write_ok) begin
        wel_q  <= 1'b0;
        pend_q <= last_byte & WR_MASK;
      end else if (arm_ok) begin
        wel_q <= 1'b1;
      end
      if (done) sr_q <= pend_q;
    end
  end
endmodule

// File: rtl/spi_status_chk.sv
module spi_status_chk #(
  parameter int CYCLE_CLKS = 1000
) (
  input logic       clk,
  input logic       rst_n,
  input logic       frame_end,
  input logic       busy,
  input logic       wel,
  input logic       srwd,
  input logic [1:0] bp,
  input logic       wp_s,
  input logic       cs_s,
  input logic       oe
);
  int run_len;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    run_len <= 0;
    else if (busy) run_len <= run_len + 1;
    else           run_len <= 0;
  end

  AST_REFUSE_UNARMED: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end && !wel && !busy |=> !busy); // R1
  AST_BUSY_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> run_len == CYCLE_CLKS); // R4
  AST_FIELDS_HELD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> $stable({srwd, bp})); // R5
  AST_WEL_LOW_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !wel); // R5
  AST_LOCK_REFUSES: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end && srwd && !wp_s && !busy |=> !busy); // R7
  AST_OE_SELECTED: assert property (@(posedge clk) disable iff (!rst_n)
    oe |-> !cs_s); // R8
endmodule

bind spi_status_ctrl spi_status_chk #(.CYCLE_CLKS(CYCLE_CLKS)) chk_i (
  .clk(clk), .rst_n(rst_n), .frame_end(frame_end), .busy(busy), .wel(wel_q),
  .srwd(sr_q[7]), .bp(sr_q[3:2]), .wp_s(wp_s), .cs_s(cs_s), .oe(spi_miso_oe)
);

// File: tb/spi_status_ctrl_tb_top.sv
module spi_status_ctrl_tb_top;
  localparam int CYC  = 300;
  localparam int HALF = 4;

  logic clk = 0, rst_n = 0, cs_n = 1, sck = 0, mosi = 0, wp_n = 1;
  logic miso, oe;
  int n_chk = 0, n_fail = 0;
  logic m_srwd = 0, m_wel = 0;
  logic [1:0] m_bp = 0;

  always #2 clk = ~clk;

  spi_status_ctrl #(.SYNC_STAGES(2), .CYCLE_CLKS(CYC)) dut_i (
    .clk(clk), .rst_n(rst_n), .spi_cs_n(cs_n), .spi_sck(sck), .spi_mosi(mosi),
    .wprot_n(wp_n), .spi_miso(miso), .spi_miso_oe(oe)
  );

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic check(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic xfer(input logic [31:0] tx, input int nbits, output logic [31:0] rx, output logic [31:0] oem);
    rx = 0; oem = 0;
    cs_n = 0; tick(HALF);
    for (int i = nbits - 1; i >= 0; i--) begin
      mosi = tx[i];
      tick(HALF);
      rx[i] = miso; oem[i] = oe;
      sck = 1; tick(HALF);
      sck = 0;
    end
    tick(HALF); cs_n = 1; tick(2 * HALF);
  endtask

  task automatic send(input logic [31:0] tx, input int nbits);
    logic [31:0] r, m;
    xfer(tx, nbits, r, m);
  endtask

  task automatic read_sr(output logic [7:0] s);
    logic [31:0] r, m;
    xfer(32'h0500, 16, r, m);
    s = r[7:0];
  endtask

  function automatic logic [7:0] exp_sr(input logic wip);
    return {m_srwd, 3'b000, m_bp, m_wel, wip};
  endfunction

  initial begin
    tick(150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [7:0] s;
    logic [31:0] r, m;
    tick(5); rst_n = 1; tick(5);

    // R10 reset state
    check(oe == 1'b0, "R10 oe after reset", {31'b0, oe}, 0);
    read_sr(s);
    check(s == 8'h00, "R10 status after reset", {24'b0, s}, 0);

    // R1 write without arming
    send(32'h018C, 16); tick(CYC + 20);
    read_sr(s);
    check(s == exp_sr(0), "R1 unarmed write refused", {24'b0, s}, {24'b0, exp_sr(0)});

    // R2 arm with 9 bits ignored, 8 bits accepted
    send({23'b0, 8'h06, 1'b0}, 9);
    read_sr(s);
    check(s == exp_sr(0), "R2 arm with 9 bits ignored", {24'b0, s}, {24'b0, exp_sr(0)});
    send(32'h06, 8); m_wel = 1;
    read_sr(s);
    check(s == exp_sr(0), "R2 arm sets latch", {24'b0, s}, {24'b0, exp_sr(0)});

    // R3 misframed writes discarded
    send({17'b0, 8'h01, 7'h46}, 15); tick(CYC + 20);
    read_sr(s);
    check(s == exp_sr(0), "R3 15-bit write discarded", {24'b0, s}, {24'b0, exp_sr(0)});
    send({15'b0, 8'h01, 8'h8C, 1'b1}, 17); tick(CYC + 20);
    read_sr(s);
    check(s == exp_sr(0), "R3 17-bit write discarded", {24'b0, s}, {24'b0, exp_sr(0)});

    // R8 continuous read and output-enable window
    xfer(32'h0500_0000, 32, r, m);
    check(r[23:0] == {3{exp_sr(0)}}, "R8 repeated status bytes", {8'b0, r[23:0]}, {8'b0, {3{exp_sr(0)}}});
    check(m == 32'h00FF_FFFF, "R8 oe only after opcode", m, 32'h00FF_FFFF);
    check(oe == 1'b0, "R8 oe low with cs high", {31'b0, oe}, 0);

    // sweep of data bytes and protect-pin levels
    for (int k = 0; k < 52; k++) begin
      logic [7:0] d;
      logic lock;
      d = 8'(k * 5);
      wp_n = (k % 3) != 0;
      send(32'h06, 8); m_wel = 1;
      tick(4);
      lock = m_srwd && !wp_n;
      send({16'b0, 8'h01, d}, 16);
      if (lock) begin
        read_sr(s);
        check(s == exp_sr(0), "R7 locked write refused", {24'b0, s}, {24'b0, exp_sr(0)});
      end else begin
        m_wel = 0;
        read_sr(s);
        check(s == exp_sr(1), "R4 busy read shows WIP, R5 latch cleared", {24'b0, s}, {24'b0, exp_sr(1)});
        if (k % 4 == 0) send(32'h06, 8); // R9 arm during busy ignored
        tick(CYC);
        m_srwd = d[7]; m_bp = d[3:2];
        read_sr(s);
        check(s == exp_sr(0), wp_n ? "R5 R6 committed fields" : "R7 R6 write with pin low and SRWD clear",
              {24'b0, s}, {24'b0, exp_sr(0)});
        check(s[6:4] == 3'b000, "R6 bits 6..4 zero", {29'b0, s[6:4]}, 0);
      end
    end

    // R9: read-status during busy works, arm ignored
    wp_n = 1;
    send(32'h06, 8); m_wel = 1; tick(4);
    send(32'h0104, 16); m_wel = 0;
    send(32'h06, 8);
    tick(CYC);
    m_srwd = 0; m_bp = 2'b01;
    read_sr(s);
    check(s == exp_sr(0), "R9 arm during busy ignored", {24'b0, s}, {24'b0, exp_sr(0)});

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule